// File: doc/BRIEF.md
# Port interrupt router with lock

This block takes the pending interrupt bits of one GPIO port, which has from 1 to 8 implemented pins, and spreads them over a set of interrupt outputs (8 by default). Each output has its own pin mask. An output is raised while any pending pin that its mask selects is high. A status read port returns the masked pending word of one selected output, so that software can tell which pins caused that output's interrupt. Bit n of the word is pin n.

Software programs the masks over a simple register bus. Reads on that bus have a one-cycle latency. A security control register sits on the same bus and holds two sticky lock bits. The write lock freezes the masks. The read lock hides the masks from bus reads. A third bit in the same register, a self-clearing command, loads every mask with the all-pins default. That command acts only while neither lock is set.

The register offsets depend on the port index. The route masks of port p begin at byte offset 0x14 + p*0x20, one 32-bit word per output. The security register is at 0x0C.

Top module: `port_irq_router`

## Requirements
- R1: After reset every route mask is zero, both lock bits are clear and every irqOut bit is low, whatever pendIn holds.
- R2: A bus write to address 0x14 + PORT*0x20 + 4*x, with x below ROUTES, stores busWdata bits [PINS-1:0] as the mask of route x. All higher mask bits read back as zero.
- R3: irqOut[x] is, in the same cycle, the OR of pendIn AND the mask of route x. Pins at PINS and above never contribute.
- R4: statusWord equals pendIn AND the mask of route statusSel, in the same cycle, with bit n for pin n. When statusSel is ROUTES or higher, statusWord is zero.
- R5: In the security register at 0x0C, bit 28 is the write lock and bit 27 is the read lock. Writing a 1 to either bit sets it. Writing 0 never clears it. Only reset clears it. A read of 0x0C returns both bits at those positions and zero in every other bit.
- R6: While the write lock is set, mask writes are ignored.
- R7: While the read lock is set, bus reads of a mask return zero. statusWord and irqOut are unaffected.
- R8: A write to 0x0C with bit 0 set loads every mask with (1 << PINS) - 1, but only if both lock bits were clear before that write. Otherwise it has no effect on the masks.
- R9: busRdata takes its new value at the clock edge that samples busRd and holds it until the next read. A read of any address other than the masks and 0x0C returns zero. A write to such an address, including a misaligned one, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| pendIn | input | 8 | Pending bit per pin |
| statusSel | input | 3 | Route whose masked status is shown |
| statusWord | output | 8 | Masked pending word of the selected route |
| irqOut | output | ROUTES | One interrupt line per route |

## Verification
The assertions take for granted that busWr, busRd and busAddr are known values whenever reset is released. The decoder's check that a single write target is selected also relies on the address map keeping the mask window clear of 0x0C, which holds for every PORT value. The bench drives all bus inputs at the falling edge and keeps them at zero between accesses. It sends one deliberately misaligned address and two addresses that border the mask window, to exercise the decode edges. pendIn and statusSel are changed only away from the rising edge, so the combinational status and interrupt outputs are checked on settled values.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int MAX_PINS      = 8;
  localparam int ROUTE_MAX     = 8;
  localparam int SEL_W         = 3;
  localparam int WORD_W        = 32;
  localparam int SEC_CTL_OFS   = 12;
  localparam int MAP_OFS       = 20;
  localparam int MAP_PORT_STEP = 32;
  localparam int WLOCK_BIT     = 28;
  localparam int RLOCK_BIT     = 27;
  localparam int SEED_BIT      = 0;

  typedef struct packed {
    logic             maskWr;
    logic             secWr;
    logic             rdMask;
    logic             rdSec;
    logic             rdAny;
    logic [SEL_W-1:0] routeSel;
  } ctrl_stb_t;
endpackage

// File: rtl/route_ctrl.sv
module route_ctrl
  import port_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PORT   = 0,
  parameter int ROUTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrl_stb_t         stb
);
  localparam int MAP_LO_I = MAP_OFS + PORT * MAP_PORT_STEP;
  localparam logic [ADDR_W-1:0] MAP_LO   = ADDR_W'(MAP_LO_I);
  localparam logic [ADDR_W-1:0] MAP_HI   = ADDR_W'(MAP_LO_I + ROUTES * 4);
  localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(SEC_CTL_OFS);

  logic [ADDR_W-1:0] offs;
  logic inMap, isSec;
  logic unusedOffs;

  always_comb begin
    offs  = busAddr - MAP_LO;
    inMap = (busAddr >= MAP_LO) && (busAddr < MAP_HI) && (busAddr[1:0] == 2'b00);
    isSec = (busAddr == SEC_ADDR);
    stb.maskWr   = busWr & inMap;
    stb.secWr    = busWr & isSec;
    stb.rdMask   = busRd & inMap;
    stb.rdSec    = busRd & isSec;
    stb.rdAny    = busRd;
    stb.routeSel = offs[SEL_W+1:2];
  end

  assign unusedOffs = ^{offs[ADDR_W-1:SEL_W+2], offs[1:0]};

  // R2
  single_write_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.maskWr, stb.secWr}));

  // R9
  read_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdMask || stb.rdSec) |-> busRd);
endmodule

// File: rtl/route_dp.sv
module route_dp
  import port_irq_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ROUTES = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_stb_t           stb,
  input  logic [WORD_W-1:0]   busWdata,
  output logic [WORD_W-1:0]   busRdata,
  input  logic [MAX_PINS-1:0] pendIn,
  input  logic [SEL_W-1:0]    statusSel,
  output logic [MAX_PINS-1:0] statusWord,
  output logic [ROUTES-1:0]   irqOut
);
  localparam logic [MAX_PINS-1:0] PIN_MASK = MAX_PINS'((1 << PINS) - 1);

  logic                secW, secR;
  logic                seedOk;
  logic [MAX_PINS-1:0] maskQ   [ROUTES];
  logic [MAX_PINS-1:0] maskArr [ROUTE_MAX];
  logic [ROUTES*MAX_PINS-1:0] maskFlat;

  assign seedOk = stb.secWr && busWdata[SEED_BIT] && !secW && !secR;

  for (genvar r = 0; r < ROUTES; r++) begin : g_route
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[r] <= '0;
      end else if (seedOk) begin
        maskQ[r] <= PIN_MASK;
      end else if (stb.maskWr && !secW && (stb.routeSel == SEL_W'(r))) begin
        maskQ[r] <= busWdata[MAX_PINS-1:0] & PIN_MASK;
      end
    end
    assign irqOut[r] = |(pendIn & maskQ[r]);
    assign maskFlat[r*MAX_PINS +: MAX_PINS] = maskQ[r];
  end

  always_comb begin
    for (int i = 0; i < ROUTE_MAX; i++) maskArr[i] = '0;
    for (int i = 0; i < ROUTES; i++) maskArr[i] = maskQ[i];
  end

  assign statusWord = pendIn & maskArr[statusSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secW <= 1'b0;
      secR <= 1'b0;
    end else if (stb.secWr) begin
      secW <= secW | busWdata[WLOCK_BIT];
      secR <= secR | busWdata[RLOCK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rdAny) begin
      busRdata <= '0;
      if (stb.rdMask && !secR) begin
        busRdata[MAX_PINS-1:0] <= maskArr[stb.routeSel];
      end else if (stb.rdSec) begin
        busRdata[WLOCK_BIT] <= secW;
        busRdata[RLOCK_BIT] <= secR;
      end
    end
  end

  // R5
  wlock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    secW |=> secW);

  // R6
  wlock_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    secW |=> $stable(maskFlat));

  // R7
  rlock_hides_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdMask && secR) |=> (busRdata == '0));

  // R3
  idle_masks_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskFlat == '0) |-> (irqOut == '0));

  // R8
  seed_needs_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.secWr && (secW || secR)) |=> $stable(maskFlat));
endmodule

// File: rtl/port_irq_router.sv
module port_irq_router
  import port_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PORT   = 0,
  parameter int PINS   = 8,
  parameter int ROUTES = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [7:0]          pendIn,
  input  logic [2:0]          statusSel,
  output logic [7:0]          statusWord,
  output logic [ROUTES-1:0]   irqOut
);
  ctrl_stb_t stb;

  route_ctrl #(.ADDR_W(ADDR_W), .PORT(PORT), .ROUTES(ROUTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .stb(stb)
  );

  route_dp #(.PINS(PINS), .ROUTES(ROUTES)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .busRdata(busRdata), .pendIn(pendIn), .statusSel(statusSel),
    .statusWord(statusWord), .irqOut(irqOut)
  );
endmodule

// File: tb/port_irq_router_tb.sv
module port_irq_router_tb_top;
  localparam int ADDR_W = 12;
  localparam int PORT   = 2;
  localparam int PINS   = 6;
  localparam int ROUTES = 8;
  localparam logic [ADDR_W-1:0] BASE = 12'h14 + 12'h20 * PORT;
  localparam logic [ADDR_W-1:0] SEC  = 12'h00C;
  localparam logic [7:0] PEND_TAB [8] = '{8'h00, 8'h3F, 8'h01, 8'h20, 8'h15, 8'h2A, 8'h0C, 8'hC0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0] pendIn = '0;
  logic [2:0] statusSel = '0;
  logic [7:0] statusWord;
  logic [ROUTES-1:0] irqOut;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  port_irq_router #(.ADDR_W(ADDR_W), .PORT(PORT), .PINS(PINS), .ROUTES(ROUTES)) dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pendIn(pendIn),
    .statusSel(statusSel), .statusWord(statusWord), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0; busAddr = '0;
    d = busRdata;
  endtask

  function automatic logic [31:0] wrPat(input int x);
    return 32'hA5A5_A500 | 32'(((x + 1) * 8'h13) & 8'hFF);
  endfunction

  function automatic logic [7:0] expMask(input int x);
    return wrPat(x)[7:0] & 8'h3F;
  endfunction

  function automatic logic [ADDR_W-1:0] mAddr(input int x);
    return BASE + ADDR_W'(4 * x);
  endfunction

  initial begin
    logic [31:0] rd;
    logic [ROUTES-1:0] expIrq;
    // reset state
    pendIn = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irqOut after reset", 32'(irqOut), 32'h0);
    check("R1 statusWord after reset", 32'(statusWord), 32'h0);
    busRead(mAddr(0), rd); check("R1 mask0 after reset", rd, 32'h0);
    busRead(SEC, rd); check("R1 security after reset", rd, 32'h0);

    // R2 mask writes and readback
    for (int x = 0; x < ROUTES; x++) busWrite(mAddr(x), wrPat(x));
    for (int x = 0; x < ROUTES; x++) begin
      busRead(mAddr(x), rd);
      check("R2 mask readback", rd, 32'(expMask(x)));
    end

    // R3/R4 table walk
    for (int t = 0; t < 8; t++) begin
      pendIn = PEND_TAB[t];
      expIrq = '0;
      for (int x = 0; x < ROUTES; x++) expIrq[x] = |(PEND_TAB[t] & expMask(x));
      #1;
      check("R3 irqOut pattern", 32'(irqOut), 32'(expIrq));
      for (int x = 0; x < ROUTES; x++) begin
        statusSel = 3'(x); #1;
        check("R4 statusWord", 32'(statusWord), 32'(PEND_TAB[t] & expMask(x)));
      end
    end

    // R9 unmapped and misaligned
    busWrite(BASE - 12'h4, 32'hFFFF_FFFF);
    busWrite(BASE + 12'h20, 32'hFFFF_FFFF);
    busWrite(BASE + 12'h1, 32'h0);
    busRead(mAddr(0), rd); check("R9 mask0 untouched", rd, 32'(expMask(0)));
    busRead(mAddr(7), rd); check("R9 mask7 untouched", rd, 32'(expMask(7)));
    busRead(BASE - 12'h4, rd); check("R9 unmapped read", rd, 32'h0);
    @(negedge clk); @(negedge clk);
    check("R9 rdata holds", busRdata, 32'h0);

    // R8 seed defaults while unlocked
    busWrite(SEC, 32'h1);
    busRead(mAddr(3), rd); check("R8 seed route3", rd, 32'h3F);
    busRead(SEC, rd); check("R8 seed leaves locks clear", rd, 32'h0);

    // R5/R6 write lock
    busWrite(mAddr(2), 32'h05);
    busWrite(SEC, 32'h1000_0000);
    busRead(SEC, rd); check("R5 write lock set", rd, 32'h1000_0000);
    busWrite(mAddr(2), 32'h3A);
    busRead(mAddr(2), rd); check("R6 locked write ignored", rd, 32'h05);
    pendIn = 8'h02; statusSel = 3'd2; #1;
    check("R6 irqOut2 unchanged", 32'(irqOut[2]), 32'h0);
    busWrite(SEC, 32'h1);
    busRead(mAddr(2), rd); check("R8 seed ignored when locked", rd, 32'h05);
    busWrite(SEC, 32'h0);
    busRead(SEC, rd); check("R5 lock sticky", rd, 32'h1000_0000);

    // R7 read lock
    busWrite(SEC, 32'h0800_0000);
    busRead(SEC, rd); check("R5 both locks", rd, 32'h1800_0000);
    busRead(mAddr(2), rd); check("R7 masked read zero", rd, 32'h0);
    pendIn = 8'h05; statusSel = 3'd2; #1;
    check("R7 status unaffected", 32'(statusWord), 32'h05);
    check("R7 irqOut unaffected", 32'(irqOut[2]), 32'h1);

    // R1 reset again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 irqOut after re-reset", 32'(irqOut), 32'h0);
    busRead(SEC, rd); check("R1 locks cleared", rd, 32'h0);
    busRead(mAddr(2), rd); check("R1 mask cleared", rd, 32'h0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule